// File: doc/BRIEF.md
# Sequential Integer Divider with Divide-Fault Decision

This block divides a double-width dividend by a single-width divisor, one quotient bit per clock, in either a narrow form (16-bit dividend, 8-bit divisor, 8-bit results) or a wide form (32-bit dividend, 16-bit divisor, 16-bit results). Operands are read as unsigned or as two's complement values. A one-cycle `start` in the idle state launches an operation. The block answers with a one-cycle `done`, together with either new quotient and remainder values or a divide fault.

A fault is raised in two cases: the divisor is zero, which is caught in the cycle `start` is taken, or the quotient does not fit the result width, which is caught after the last iteration. On a fault the result registers keep their earlier contents. The block then reports a restart address picked by `legacy_mode`. Legacy behaviour reports the address of the following instruction and also treats the most negative signed quotient as an overflow. Newer behaviour reports the address of the divide itself and accepts that value. Decode, register storage and the delivery of the fault to software belong to the surrounding design.

Top module: `intdiv_fault`

## Requirements
- R1: An unsigned divide returns the truncated quotient and the remainder. The narrow form (`wide`=0) reads only `dividend[15:0]` and `divisor[7:0]`. It places its 8-bit results in bits [7:0] of `quotient` and `remainder`, with bits [15:8] zero. The wide form (`wide`=1) uses all bits of both operands.
- R2: A signed divide (`is_signed`=1) rounds the quotient toward zero. The remainder takes the sign of the dividend. Both are written in two's complement at the width of the form.
- R3: A divisor that is zero in the selected form, including a narrow divisor whose bits [7:0] are zero, gives `done` and `fault` high in the first cycle after `start` is taken. No iteration runs.
- R4: An unsigned quotient of 2^N or more (N = 8 narrow, 16 wide) raises the fault. So does a positive signed quotient above 2^(N-1)-1.
- R5: With `legacy_mode`=0, a signed quotient of exactly -2^(N-1) (80h narrow, 8000h wide) completes without a fault.
- R6: With `legacy_mode`=1, a signed quotient of exactly -2^(N-1) raises the fault.
- R7: When the fault is raised, `quotient` and `remainder` keep the values they held before. They change only in a cycle where `done` is high and `fault` is low.
- R8: On a fault, `fault_addr` takes `next_addr` when `legacy_mode`=1, or `instr_addr` when it is 0, using the values present when `start` was taken. It does not change at any other time.
- R9: With a nonzero divisor, `done` rises 2N+1 cycles after `start` is taken: 17 narrow, 33 wide. `busy` is high from the cycle after `start` until `done` rises, and it is low while `done` is high.
- R10: A `start` that arrives while `busy` is high is ignored and does not alter the running operation.
- R11: `done` lasts exactly one cycle. `fault` is high only together with `done`. After reset, `done`, `fault` and `busy` are low, and `quotient`, `remainder` and `fault_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch an operation; taken only when idle |
| is_signed | input | 1 | 1 = two's complement operands |
| wide | input | 1 | 1 = 32/16 form, 0 = 16/8 form |
| legacy_mode | input | 1 | 1 = legacy fault behaviour |
| dividend | input | 32 | Dividend (low 16 bits in narrow form) |
| divisor | input | 16 | Divisor (low 8 bits in narrow form) |
| instr_addr | input | 16 | Address of the divide instruction |
| next_addr | input | 16 | Address of the following instruction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide fault, valid with `done` |
| quotient | output | 16 | Quotient register |
| remainder | output | 16 | Remainder register |
| fault_addr | output | 16 | Restart address reported on a fault |

## Verification
Several properties are checked on every cycle. A zero divisor is answered in the next cycle with a fault and the address chosen by the mode. The results hold across a fault and change only on a good completion. `done` is a single pulse, `fault` never appears without it, and `busy` and `done` are never high together. The arithmetic itself cannot be checked that way, and neither can the range limits per form and sign or the exact 17- and 33-cycle latencies. The 80h/8000h corner flipping between the two modes and the dropping of a second `start` likewise need the bench scenarios, which are compared against the reference model.

// File: rtl/intdiv_pkg.sv
// Shared types for the sequential divider.
// Assumes nothing beyond a single clock domain.
package intdiv_pkg;

    // Controller phases: waiting, iterating, settling the result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

endpackage

// File: rtl/intdiv_prep.sv
// Operand preparation: picks the operand bits of the selected form,
// takes magnitudes of signed operands, aligns a narrow dividend to the
// top of the shift register, flags a zero divisor and gives the
// iteration count. Purely combinational.
// Assumes NARROW_W < WIDE_W.
module intdiv_prep #(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int CNT_W    = $clog2(2*WIDE_W+1)
) (
    input  logic [2*WIDE_W-1:0] dividend,
    input  logic [WIDE_W-1:0]   divisor,
    input  logic                is_signed,
    input  logic                wide,
    output logic [2*WIDE_W-1:0] dvd_mag,
    output logic [WIDE_W-1:0]   dvs_mag,
    output logic                dvd_neg,
    output logic                dvs_neg,
    output logic                dvs_zero,
    output logic [CNT_W-1:0]    iter
);
    localparam int DW    = 2*WIDE_W;
    localparam int NDW   = 2*NARROW_W;
    localparam int ALIGN = DW - NDW;

    logic [NDW-1:0]      nar_dvd;
    logic [NARROW_W-1:0] nar_dvs;

    // Magnitudes and signs for the selected form.
    always_comb begin
        nar_dvd = '0;
        nar_dvs = '0;
        if (wide) begin
            dvd_neg = is_signed & dividend[DW-1];
            dvs_neg = is_signed & divisor[WIDE_W-1];
            dvd_mag = dvd_neg ? (~dividend) + DW'(1) : dividend;
            dvs_mag = dvs_neg ? (~divisor) + WIDE_W'(1) : divisor;
        end else begin
            dvd_neg = is_signed & dividend[NDW-1];
            dvs_neg = is_signed & divisor[NARROW_W-1];
            nar_dvd = dvd_neg ? (~dividend[NDW-1:0]) + NDW'(1) : dividend[NDW-1:0];
            nar_dvs = dvs_neg ? (~divisor[NARROW_W-1:0]) + NARROW_W'(1)
                              : divisor[NARROW_W-1:0];
            dvd_mag = {nar_dvd, {ALIGN{1'b0}}};
            dvs_mag = WIDE_W'(nar_dvs);
        end
    end

    // Zero divisor flag and number of quotient bits to produce.
    always_comb begin
        dvs_zero = (dvs_mag == '0);
        iter     = wide ? CNT_W'(DW) : CNT_W'(NDW);
    end

endmodule

// File: rtl/intdiv_core.sv
// Restoring shift-subtract engine: each step shifts one dividend bit
// into the partial remainder and writes one quotient bit.
// Assumes divisor magnitude nonzero; the partial remainder then stays
// below the divisor, so a W+1-bit difference detects the borrow.
module intdiv_core #(
    parameter int WIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [2*WIDE_W-1:0] dvd_in,
    input  logic [WIDE_W-1:0]   dvs_in,
    output logic [2*WIDE_W-1:0] quo_mag,
    output logic [WIDE_W-1:0]   rem_mag
);
    localparam int DW = 2*WIDE_W;

    logic [WIDE_W-1:0] acc_q;
    logic [DW-1:0]     quo_q;
    logic [WIDE_W-1:0] dvs_q;
    logic [WIDE_W:0]   shifted;
    logic [WIDE_W:0]   diff;
    logic              fits;

    // Trial subtraction of the divisor from the shifted remainder.
    always_comb begin
        shifted = {acc_q, quo_q[DW-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = ~diff[WIDE_W];
    end

    // Load operands or advance one quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            acc_q <= '0;
            quo_q <= dvd_in;
            dvs_q <= dvs_in;
        end else if (step) begin
            acc_q <= fits ? diff[WIDE_W-1:0] : shifted[WIDE_W-1:0];
            quo_q <= {quo_q[DW-2:0], fits};
        end
    end

    assign quo_mag = quo_q;
    assign rem_mag = acc_q;

endmodule

// File: rtl/intdiv_fixup.sv
// Result settling: range check of the quotient magnitude against the
// limit for form, sign and mode, then sign restoration and zero
// extension of narrow results. Purely combinational.
// Assumes quo_mag holds the full quotient magnitude of the form.
module intdiv_fixup #(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic [2*WIDE_W-1:0] quo_mag,
    input  logic [WIDE_W-1:0]   rem_mag,
    input  logic                wide,
    input  logic                is_signed,
    input  logic                legacy,
    input  logic                q_neg,
    input  logic                r_neg,
    output logic [WIDE_W-1:0]   q_out,
    output logic [WIDE_W-1:0]   r_out,
    output logic                ovf
);
    localparam int DW = 2*WIDE_W;

    logic [DW-1:0]     lim_uns [2];
    logic [DW-1:0]     lim_pos [2];
    logic [DW-1:0]     lim_neg [2];
    logic [DW-1:0]     limit;
    logic [WIDE_W-1:0] q_tc;
    logic [WIDE_W-1:0] r_tc;

    // Per-form limits: index 0 narrow, index 1 wide.
    for (genvar f = 0; f < 2; f++) begin : g_lim
        localparam int FW = (f == 1) ? WIDE_W : NARROW_W;
        assign lim_uns[f] = (DW'(1) << FW) - DW'(1);
        assign lim_pos[f] = (DW'(1) << (FW-1)) - DW'(1);
        assign lim_neg[f] = (DW'(1) << (FW-1));
    end

    // Largest magnitude that still fits, and the overflow decision.
    always_comb begin
        if (!is_signed)
            limit = lim_uns[wide];
        else if (q_neg && !legacy)
            limit = lim_neg[wide];
        else
            limit = lim_pos[wide];
        ovf = (quo_mag > limit);
    end

    // Restore signs and clear the upper half for the narrow form.
    always_comb begin
        q_tc  = q_neg ? (~quo_mag[WIDE_W-1:0]) + WIDE_W'(1) : quo_mag[WIDE_W-1:0];
        r_tc  = r_neg ? (~rem_mag) + WIDE_W'(1) : rem_mag;
        q_out = wide ? q_tc : {{(WIDE_W-NARROW_W){1'b0}}, q_tc[NARROW_W-1:0]};
        r_out = wide ? r_tc : {{(WIDE_W-NARROW_W){1'b0}}, r_tc[NARROW_W-1:0]};
    end

endmodule

// File: rtl/intdiv_fault.sv
// Sequential integer divider with divide-fault decision.
// Takes start only when idle. A zero divisor faults at once; otherwise
// it iterates 2N cycles, settles in one more and either writes results
// or faults on overflow. Result registers hold across faults.
// Assumes the caller keeps operands valid in the start cycle only.
module intdiv_fault #(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int ADDR_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                is_signed,
    input  logic                wide,
    input  logic                legacy_mode,
    input  logic [2*WIDE_W-1:0] dividend,
    input  logic [WIDE_W-1:0]   divisor,
    input  logic [ADDR_W-1:0]   instr_addr,
    input  logic [ADDR_W-1:0]   next_addr,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [WIDE_W-1:0]   quotient,
    output logic [WIDE_W-1:0]   remainder,
    output logic [ADDR_W-1:0]   fault_addr
);
    import intdiv_pkg::*;

    localparam int DW    = 2*WIDE_W;
    localparam int CNT_W = $clog2(DW+1);

    div_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cap_signed, cap_wide, cap_legacy, cap_qneg, cap_rneg;
    logic [ADDR_W-1:0] cap_addr;
    logic              done_q, fault_q;
    logic [WIDE_W-1:0] quo_q, rem_q;
    logic [ADDR_W-1:0] faddr_q;

    logic [DW-1:0]     dvd_mag, quo_mag;
    logic [WIDE_W-1:0] dvs_mag, rem_mag, q_out, r_out;
    logic              dvd_neg, dvs_neg, dvs_zero, ovf;
    logic [CNT_W-1:0]  iter;
    logic              take, launch;

    intdiv_prep #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W)) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .is_signed(is_signed),
        .wide     (wide),
        .dvd_mag  (dvd_mag),
        .dvs_mag  (dvs_mag),
        .dvd_neg  (dvd_neg),
        .dvs_neg  (dvs_neg),
        .dvs_zero (dvs_zero),
        .iter     (iter)
    );

    intdiv_core #(.WIDE_W(WIDE_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .step   (state_q == ST_RUN),
        .dvd_in (dvd_mag),
        .dvs_in (dvs_mag),
        .quo_mag(quo_mag),
        .rem_mag(rem_mag)
    );

    intdiv_fixup #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_fix (
        .quo_mag  (quo_mag),
        .rem_mag  (rem_mag),
        .wide     (cap_wide),
        .is_signed(cap_signed),
        .legacy   (cap_legacy),
        .q_neg    (cap_qneg),
        .r_neg    (cap_rneg),
        .q_out    (q_out),
        .r_out    (r_out),
        .ovf      (ovf)
    );

    // Accept decisions for an incoming start.
    always_comb begin
        take   = (state_q == ST_IDLE) && start;
        launch = take && !dvs_zero;
    end

    // Phase sequencing and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (launch) begin
                    state_q <= ST_RUN;
                    cnt_q   <= iter;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture of operation attributes when an operation is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_signed <= 1'b0;
            cap_wide   <= 1'b0;
            cap_legacy <= 1'b0;
            cap_qneg   <= 1'b0;
            cap_rneg   <= 1'b0;
            cap_addr   <= '0;
        end else if (launch) begin
            cap_signed <= is_signed;
            cap_wide   <= wide;
            cap_legacy <= legacy_mode;
            cap_qneg   <= dvd_neg ^ dvs_neg;
            cap_rneg   <= dvd_neg;
            cap_addr   <= legacy_mode ? next_addr : instr_addr;
        end
    end

    // Completion pulse, fault flag, result and restart address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            quo_q   <= '0;
            rem_q   <= '0;
            faddr_q <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            if (take && dvs_zero) begin
                done_q  <= 1'b1;
                fault_q <= 1'b1;
                faddr_q <= legacy_mode ? next_addr : instr_addr;
            end else if (state_q == ST_FIN) begin
                done_q <= 1'b1;
                if (ovf) begin
                    fault_q <= 1'b1;
                    faddr_q <= cap_addr;
                end else begin
                    quo_q <= q_out;
                    rem_q <= r_out;
                end
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign fault      = fault_q;
    assign quotient   = quo_q;
    assign remainder  = rem_q;
    assign fault_addr = faddr_q;

endmodule

// File: rtl/intdiv_fault_chk.sv
// Property checker for intdiv_fault, attached by bind below.
// Observes ports only.
module intdiv_fault_chk #(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int ADDR_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wide,
    input logic              legacy_mode,
    input logic [WIDE_W-1:0] divisor,
    input logic [ADDR_W-1:0] instr_addr,
    input logic [ADDR_W-1:0] next_addr,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [WIDE_W-1:0] quotient,
    input logic [WIDE_W-1:0] remainder,
    input logic [ADDR_W-1:0] fault_addr
);
    logic zero_take;
    assign zero_take = start && !busy &&
                       (wide ? (divisor == '0) : (divisor[NARROW_W-1:0] == '0));

    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        zero_take |=> (done && fault)); // R3
    AST_ZERO_ADDR_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_take && legacy_mode) |=> (fault_addr == $past(next_addr))); // R8
    AST_ZERO_ADDR_NEWER: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_take && !legacy_mode) |=> (fault_addr == $past(instr_addr))); // R8
    AST_HOLD_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> ($stable(quotient) && $stable(remainder))); // R7
    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder))); // R7
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault) |-> $stable(fault_addr)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done); // R11
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R9

endmodule

bind intdiv_fault intdiv_fault_chk #(
    .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wide       (wide),
    .legacy_mode(legacy_mode),
    .divisor    (divisor),
    .instr_addr (instr_addr),
    .next_addr  (next_addr),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .quotient   (quotient),
    .remainder  (remainder),
    .fault_addr (fault_addr)
);

// File: tb/intdiv_fault_test.sv
// Bench for intdiv_fault: behavioural reference model compared with the
// ports at every falling edge, plus directed scenario checks.
module intdiv_fault_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic        wide = 1'b0;
    logic        legacy_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [15:0] instr_addr = '0;
    logic [15:0] next_addr = '0;
    logic        busy, done, fault;
    logic [15:0] quotient, remainder, fault_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model state
    int          m_cnt = 0;
    bit          m_done = 0, m_fault = 0;
    logic [15:0] m_q = '0, m_r = '0, m_addr = '0;
    bit          p_fault = 0;
    logic [15:0] p_q = '0, p_r = '0, p_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intdiv_fault uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .wide(wide), .legacy_mode(legacy_mode), .dividend(dividend),
        .divisor(divisor), .instr_addr(instr_addr), .next_addr(next_addr),
        .busy(busy), .done(done), .fault(fault), .quotient(quotient),
        .remainder(remainder), .fault_addr(fault_addr)
    );

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Evaluates an operation from the requirements; returns 1 on zero divisor.
    function automatic bit model_eval();
        longint n, a, b, q, r, lo, hi, mask;
        n    = wide ? 16 : 8;
        mask = (longint'(1) << n) - 1;
        a    = longint'(dividend) & ((longint'(1) << (2*n)) - 1);
        b    = longint'(divisor) & mask;
        if (is_signed) begin
            if (((a >> (2*n-1)) & 1) != 0) a = a - (longint'(1) << (2*n));
            if (((b >> (n-1)) & 1) != 0)   b = b - (longint'(1) << n);
        end
        p_addr = legacy_mode ? next_addr : instr_addr;
        if (b == 0) return 1'b1;
        q = a / b;
        r = a % b;
        if (!is_signed) begin
            lo = 0;
            hi = mask;
        end else begin
            hi = (longint'(1) << (n-1)) - 1;
            lo = legacy_mode ? -hi : -(hi + 1);
        end
        p_fault = (q > hi) || (q < lo);
        p_q = 16'(q & mask);
        p_r = 16'(r & mask);
        return 1'b0;
    endfunction

    // Cycle model: advances on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_fault = 0;
            m_q = '0; m_r = '0; m_addr = '0;
        end else begin
            m_done = 0;
            m_fault = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1;
                    m_fault = p_fault;
                    if (p_fault) m_addr = p_addr;
                    else begin m_q = p_q; m_r = p_r; end
                end
            end else if (start) begin
                if (model_eval()) begin
                    m_done = 1; m_fault = 1; m_addr = p_addr;
                end else begin
                    m_cnt = wide ? 33 : 17;
                end
            end
        end
    end

    // Every-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R9 busy", busy, m_cnt > 0);
            check("R11 done", done, m_done);
            check("R11 fault", fault, m_fault);
            check("R7 quotient", quotient, m_q);
            check("R7 remainder", remainder, m_r);
            check("R8 fault_addr", fault_addr, m_addr);
        end
    end

    // Runs one operation; returns cycles from start to done.
    task automatic run_op(input bit sg, input bit wd, input bit lg,
                          input logic [31:0] dd, input logic [15:0] ds,
                          output int cycles);
        @(negedge clk);
        is_signed = sg; wide = wd; legacy_mode = lg;
        dividend = dd; divisor = ds;
        instr_addr = instr_addr + 16'h0100;
        next_addr = instr_addr + 16'h0002;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (!done && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int cyc;
        logic [15:0] old_addr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 reset done", done, 0);
        check("R11 reset busy", busy, 0);
        check("R11 reset quotient", quotient, 0);
        check("R11 reset fault_addr", fault_addr, 0);

        // R1 narrow unsigned, upper operand bits are garbage
        run_op(0, 0, 0, 32'hABCD_03E8, 16'h5507, cyc);
        check("R1 narrow q", quotient, 16'h008E);
        check("R1 narrow r", remainder, 16'h0006);
        check("R9 narrow latency", cyc, 17);
        @(negedge clk);
        check("R11 done one cycle", done, 0);

        // R1 wide unsigned
        run_op(0, 1, 0, 32'd100000, 16'd300, cyc);
        check("R1 wide q", quotient, 16'd333);
        check("R1 wide r", remainder, 16'd100);
        check("R9 wide latency", cyc, 33);

        // R2 signed narrow -100/7
        run_op(1, 0, 0, 32'h0000_FF9C, 16'h0007, cyc);
        check("R2 narrow q", quotient, 16'h00F2);
        check("R2 narrow r", remainder, 16'h00FE);

        // R2 signed wide -7/2
        run_op(1, 1, 0, 32'hFFFF_FFF9, 16'h0002, cyc);
        check("R2 wide q", quotient, 16'hFFFD);
        check("R2 wide r", remainder, 16'hFFFF);

        // R4 unsigned narrow overflow, R7 hold, R8 newer address
        run_op(0, 0, 0, 32'h0000_1000, 16'h0002, cyc);
        check("R4 unsigned ovf fault", fault, 1);
        check("R7 held q", quotient, 16'hFFFD);
        check("R8 newer addr", fault_addr, instr_addr);

        // R4 signed positive overflow 256/2
        run_op(1, 0, 0, 32'h0000_0100, 16'h0002, cyc);
        check("R4 signed ovf fault", fault, 1);

        // R5 newer narrow -256/2 = 80h accepted
        run_op(1, 0, 0, 32'h0000_FF00, 16'h0002, cyc);
        check("R5 narrow fault", fault, 0);
        check("R5 narrow q", quotient, 16'h0080);

        // R6 legacy narrow same case faults, R8 legacy address
        run_op(1, 0, 1, 32'h0000_FF00, 16'h0002, cyc);
        check("R6 narrow fault", fault, 1);
        check("R7 held after legacy", quotient, 16'h0080);
        check("R8 legacy addr", fault_addr, next_addr);

        // R5 / R6 wide 8000h corner
        run_op(1, 1, 0, 32'hFFFF_0000, 16'h0002, cyc);
        check("R5 wide q", quotient, 16'h8000);
        old_addr = fault_addr;
        check("R8 addr kept on success", fault_addr, old_addr);
        run_op(1, 1, 1, 32'hFFFF_0000, 16'h0002, cyc);
        check("R6 wide fault", fault, 1);

        // R3 zero divisor: wide, then narrow with nonzero upper bits
        run_op(0, 1, 0, 32'd55, 16'h0000, cyc);
        check("R3 wide zero fault", fault, 1);
        check("R3 wide zero latency", cyc, 0);
        run_op(1, 0, 1, 32'd55, 16'h1200, cyc);
        check("R3 narrow zero fault", fault, 1);
        check("R3 narrow zero latency", cyc, 0);
        check("R8 zero legacy addr", fault_addr, next_addr);

        // R10 start while busy is ignored
        @(negedge clk);
        is_signed = 0; wide = 1; legacy_mode = 0;
        dividend = 32'd50000; divisor = 16'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dividend = 32'd9; divisor = 16'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check("R10 first op q", quotient, 16'd7142);
        check("R10 first op r", remainder, 16'd6);
        repeat (3) @(negedge clk);
        check("R10 no second done", busy, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule